// File: doc/BRIEF.md
# Scanline Horizontal Timing Generator

This block produces the horizontal timing of a raster video controller. A free-running position counter steps once per clock through each scanline, and every clock the position is compared against a small set of fixed points to raise and drop a display-enable signal and a horizontal blank, and to mark the first cycle of each line. The line rate follows from two CPU-written registers: a resolution register and a sync register. They are folded into one of three modes: 50 Hz, 60 Hz or high resolution.

Each mode has its own line-end test at its own position, and only the test for the mode in force at that exact clock can drop display-enable. Software that changes mode between the 60 Hz test and the 50 Hz test therefore keeps display-enable high into the right border. The two registers are captured with different timing relative to the CPU write strobe, so the exact write cycle matters and the block reproduces that skew.

Top module: `line_timer`

## Requirements
- R1: The mode is high resolution whenever bit 1 of the resolution register is 1. Otherwise bit 1 of the sync register selects 50 Hz (1) or 60 Hz (0).
- R2: A line lasts 512 clocks in 50 Hz mode, 508 in 60 Hz mode and 224 in high-resolution mode. The length is taken from the mode at position 0 and holds for the whole line even if the mode changes later. `line_start` is 1 exactly while `line_pos` is 0.
- R3: One clock after the position reads 6 in 50 Hz or 60 Hz mode, or 4 in high-resolution mode, `disp_en` is 1, unless external sync is selected.
- R4: If the position is 372 and the mode at that clock is 60 Hz, `disp_en` is 0 on the next clock.
- R5: If the position is 376 and the mode at that clock is 50 Hz, `disp_en` is 0 on the next clock.
- R6: If the position is 184 and the mode at that clock is high resolution, `disp_en` is 0 on the next clock.
- R7: When none of the end tests of R4 to R6 match, `disp_en` stays 1 past the line end and into the next line. Examples: the mode is 50 Hz at 372 and 60 Hz at 376, or high resolution at 376.
- R8: A resolution write (`wr_sel`=0) takes `wr_data[1]` in the first clock of the strobe. The new mode is in force one clock later.
- R9: A sync write (`wr_sel`=1) takes `wr_data` as it stands in the last clock of the strobe. The new value is in force two clocks after that last strobe clock, and nothing changes while the strobe is still high.
- R10: When sync register bit 0 is 1 (external sync), `sync_drive` is 0 and `disp_en` is held at 0 from the clock after the value takes effect.
- R11: `hblank` is 1 from position 0 through position 32 and 0 from position 33 to the end of the line.
- R12: During and after reset the position is 0, `disp_en` is 0, `hblank` is 1 and `sync_drive` is 1. The registers start as resolution bit 0 and sync 2'b10 (internal sync, 50 Hz), so the first line is 512 clocks long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | CPU write strobe, high for one or more clocks |
| wr_sel | input | 1 | Register select: 0 resolution, 1 sync |
| wr_data | input | 2 | Write data |
| disp_en | output | 1 | Display enable |
| hblank | output | 1 | Horizontal blank |
| line_start | output | 1 | High on the first clock of each line |
| sync_drive | output | 1 | 1 while the block drives its own sync and enable |
| line_pos | output | 9 | Current position within the line |

## Verification
The assertions check on every clock that the counter steps by one and that `line_start` is a single-clock pulse. They also check that each mode's end test drops `disp_en` on the next clock, that the start points raise it, that blanking follows the position, that external sync forces `disp_en` low, and that the sync value never moves without a strobe falling edge. What only the directed scenarios can show is how these interact at chosen write cycles. That covers the border left open by a 50-to-60 switch between 372 and 376, the one-clock difference between a resolution write and a sync write landing on the same cycle, a long sync strobe whose data changes before its last clock, a line whose length stays as sampled after a mode change, and the precedence of high resolution over the sync bit.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

  typedef enum logic [1:0] {
    MODE_50 = 2'd0,
    MODE_60 = 2'd1,
    MODE_HI = 2'd2
  } lt_mode_e;

  localparam logic SEL_RES  = 1'b0;
  localparam logic SEL_SYNC = 1'b1;

endpackage

// File: rtl/lt_reg_capture.sv
`timescale 1ns/1ps
// Captures the two mode registers with their distinct strobe timing.
module lt_reg_capture #(
  parameter logic [1:0] RST_SYNC = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       wr_sel,
  input  logic [1:0] wr_data,
  output logic       res_hi,
  output logic [1:0] sync_val
);
  import lt_pkg::*;

  logic       stb_q, stb_d;
  logic       pend_q, pend_d;
  logic [1:0] hold_q, hold_d;
  logic       res_q, res_d;
  logic [1:0] sync_q, sync_d;
  logic       stb_rise, stb_fall;

  always_comb begin
    stb_rise = wr_stb & ~stb_q;
    stb_fall = ~wr_stb & stb_q;
    stb_d    = wr_stb;
    // resolution: sampled at the leading edge of the strobe
    res_d    = (stb_rise && wr_sel == SEL_RES) ? wr_data[1] : res_q;
    // sync: remember the target, follow data while strobe is high
    if (stb_rise)      pend_d = (wr_sel == SEL_SYNC);
    else if (stb_fall) pend_d = 1'b0;
    else               pend_d = pend_q;
    hold_d   = wr_stb ? wr_data : hold_q;
    // sync: committed at the trailing edge of the strobe
    sync_d   = (stb_fall && pend_q) ? hold_q : sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= 2'b00;
      res_q  <= 1'b0;
      sync_q <= RST_SYNC;
    end else begin
      stb_q  <= stb_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
      res_q  <= res_d;
      sync_q <= sync_d;
    end
  end

  assign res_hi   = res_q;
  assign sync_val = sync_q;

endmodule

// File: rtl/lt_mode_decode.sv
`timescale 1ns/1ps
// Folds the two registers into one line-rate mode and its line length.
module lt_mode_decode #(
  parameter int LEN50 = 512,
  parameter int LEN60 = 508,
  parameter int LENHI = 224,
  parameter int CW    = 9
) (
  input  logic             res_hi,
  input  logic [1:0]       sync_val,
  output lt_pkg::lt_mode_e mode,
  output logic             ext_sync,
  output logic [CW-1:0]    last_pos
);
  import lt_pkg::*;

  localparam logic [CW-1:0] LAST50 = CW'(LEN50 - 1);
  localparam logic [CW-1:0] LAST60 = CW'(LEN60 - 1);
  localparam logic [CW-1:0] LASTHI = CW'(LENHI - 1);

  always_comb begin
    if (res_hi)           mode = MODE_HI;
    else if (sync_val[1]) mode = MODE_50;
    else                  mode = MODE_60;
    ext_sync = sync_val[0];
    case (mode)
      MODE_HI: last_pos = LASTHI;
      MODE_60: last_pos = LAST60;
      default: last_pos = LAST50;
    endcase
  end

endmodule

// File: rtl/lt_hcount.sv
`timescale 1ns/1ps
// Line position counter; the line length is latched at position 0.
module lt_hcount #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] next_last,
  output logic [CW-1:0] pos,
  output logic          line_end,
  output logic          line_first
);
  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] last_q, last_d;

  always_comb begin
    line_first = (pos_q == '0);
    line_end   = (pos_q == last_q);
    pos_d      = line_end ? '0 : pos_q + 1'b1;
    last_d     = line_first ? next_last : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      last_q <= '1;
    end else begin
      pos_q  <= pos_d;
      last_q <= last_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/lt_edges.sv
`timescale 1ns/1ps
// Position compares that set and clear display enable and blank.
module lt_edges #(
  parameter int CW       = 9,
  parameter int DE_ON    = 6,
  parameter int HI_DE_ON = 4,
  parameter int OFF60    = 372,
  parameter int OFF50    = 376,
  parameter int OFFHI    = 184,
  parameter int HB_OFF   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    pos,
  input  logic             line_end,
  input  lt_pkg::lt_mode_e mode,
  input  logic             ext_sync,
  output logic             disp_en,
  output logic             hblank
);
  import lt_pkg::*;

  localparam logic [CW-1:0] P_ON   = CW'(DE_ON);
  localparam logic [CW-1:0] P_HION = CW'(HI_DE_ON);
  localparam logic [CW-1:0] P_60   = CW'(OFF60);
  localparam logic [CW-1:0] P_50   = CW'(OFF50);
  localparam logic [CW-1:0] P_HI   = CW'(OFFHI);
  localparam logic [CW-1:0] P_HB   = CW'(HB_OFF);

  logic de_q, de_d, hb_q, hb_d;
  logic hit_clr, hit_set;

  always_comb begin
    // one compare per mode, each only live in its own mode
    hit_clr = (pos == P_60 && mode == MODE_60) ||
              (pos == P_50 && mode == MODE_50) ||
              (pos == P_HI && mode == MODE_HI);
    hit_set = (mode == MODE_HI) ? (pos == P_HION) : (pos == P_ON);
    if (ext_sync)     de_d = 1'b0;
    else if (hit_clr) de_d = 1'b0;
    else if (hit_set) de_d = 1'b1;
    else              de_d = de_q;
    if (line_end)       hb_d = 1'b1;
    else if (pos == P_HB) hb_d = 1'b0;
    else                hb_d = hb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      hb_q <= 1'b1;
    end else begin
      de_q <= de_d;
      hb_q <= hb_d;
    end
  end

  assign disp_en = de_q;
  assign hblank  = hb_q;

endmodule

// File: rtl/line_timer.sv
`timescale 1ns/1ps
module line_timer #(
  parameter int LEN50    = 512,
  parameter int LEN60    = 508,
  parameter int LENHI    = 224,
  parameter int DE_ON    = 6,
  parameter int HI_DE_ON = 4,
  parameter int OFF60    = 372,
  parameter int OFF50    = 376,
  parameter int OFFHI    = 184,
  parameter int HB_OFF   = 32,
  parameter int MAXLEN   = (LEN50 > LEN60) ? ((LEN50 > LENHI) ? LEN50 : LENHI)
                                           : ((LEN60 > LENHI) ? LEN60 : LENHI),
  parameter int CW       = $clog2(MAXLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          wr_sel,
  input  logic [1:0]    wr_data,
  output logic          disp_en,
  output logic          hblank,
  output logic          line_start,
  output logic          sync_drive,
  output logic [CW-1:0] line_pos
);
  import lt_pkg::*;

  logic             rst_meta_q, rst_sync_n;
  logic             res_hi;
  logic [1:0]       sync_val;
  lt_mode_e         mode;
  logic             ext_sync;
  logic [CW-1:0]    next_last;
  logic             line_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lt_reg_capture #(.RST_SYNC(2'b10)) cap_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .res_hi(res_hi), .sync_val(sync_val)
  );

  lt_mode_decode #(.LEN50(LEN50), .LEN60(LEN60), .LENHI(LENHI), .CW(CW)) dec_i (
    .res_hi(res_hi), .sync_val(sync_val), .mode(mode),
    .ext_sync(ext_sync), .last_pos(next_last)
  );

  lt_hcount #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_sync_n), .next_last(next_last),
    .pos(line_pos), .line_end(line_end), .line_first(line_start)
  );

  lt_edges #(.CW(CW), .DE_ON(DE_ON), .HI_DE_ON(HI_DE_ON), .OFF60(OFF60),
             .OFF50(OFF50), .OFFHI(OFFHI), .HB_OFF(HB_OFF)) edg_i (
    .clk(clk), .rst_n(rst_sync_n), .pos(line_pos), .line_end(line_end),
    .mode(mode), .ext_sync(ext_sync), .disp_en(disp_en), .hblank(hblank)
  );

  assign sync_drive = ~ext_sync;

endmodule

// File: rtl/line_timer_chk.sv
`timescale 1ns/1ps
module line_timer_chk #(
  parameter int CW       = 9,
  parameter int DE_ON    = 6,
  parameter int HI_DE_ON = 4,
  parameter int OFF60    = 372,
  parameter int OFF50    = 376,
  parameter int OFFHI    = 184,
  parameter int HB_OFF   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             wr_sel,
  input logic [1:0]       wr_data,
  input logic [CW-1:0]    line_pos,
  input logic             line_start,
  input logic             disp_en,
  input logic             hblank,
  input logic             sync_drive,
  input lt_pkg::lt_mode_e mode,
  input logic             res_hi,
  input logic [1:0]       sync_val
);
  import lt_pkg::*;

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos != '0) |-> (line_pos == CW'($past(line_pos) + 1)));
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);
  // R3
  de_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_drive && ((mode != MODE_HI && line_pos == CW'(DE_ON)) ||
                    (mode == MODE_HI && line_pos == CW'(HI_DE_ON)))) |=> disp_en);
  // R4
  end60_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos == CW'(OFF60) && mode == MODE_60) |=> !disp_en);
  // R5
  end50_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos == CW'(OFF50) && mode == MODE_50) |=> !disp_en);
  // R6
  endhi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos == CW'(OFFHI) && mode == MODE_HI) |=> !disp_en);
  // R8
  res_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !$past(wr_stb) && wr_sel == SEL_RES) |=> (res_hi == $past(wr_data[1])));
  // R9
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !$past(wr_stb)) |=> $stable(sync_val));
  // R10
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_drive |=> !disp_en);
  // R11
  blank_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> hblank);
  // R11
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos > CW'(HB_OFF)) |-> !hblank);

endmodule

bind line_timer line_timer_chk #(
  .CW(CW), .DE_ON(DE_ON), .HI_DE_ON(HI_DE_ON), .OFF60(OFF60),
  .OFF50(OFF50), .OFFHI(OFFHI), .HB_OFF(HB_OFF)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
  .wr_data(wr_data), .line_pos(line_pos), .line_start(line_start),
  .disp_en(disp_en), .hblank(hblank), .sync_drive(sync_drive),
  .mode(mode), .res_hi(res_hi), .sync_val(sync_val)
);

// File: tb/line_timer_tb_top.sv
`timescale 1ns/1ps
module line_timer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic       wr_sel;
  logic [1:0] wr_data;
  logic       disp_en, hblank, line_start, sync_drive;
  logic [8:0] line_pos;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  line_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .disp_en(disp_en), .hblank(hblank),
    .line_start(line_start), .sync_drive(sync_drive), .line_pos(line_pos)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, line_pos);
    end
  endtask

  task automatic wait_pos(input int p);
    forever begin
      @(negedge clk);
      if (int'(line_pos) == p) break;
    end
  endtask

  // single-clock strobe in the current cycle; returns one cycle later
  task automatic wr(input logic sel, input logic [1:0] d);
    wr_stb = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_stb = 1'b0; wr_sel = 1'b0; wr_data = 2'b00;
    repeat (3) @(negedge clk);
    check("R12 pos", int'(line_pos), 0);
    check("R12 disp_en", int'(disp_en), 0);
    check("R12 hblank", int'(hblank), 1);
    check("R12 sync_drive", int'(sync_drive), 1);
    rst_n = 1'b1;
    wait_pos(5);
  endtask

  task automatic t_line50;
    wait_pos(511); @(negedge clk);
    check("R12 first line 512", int'(line_pos), 0);
    check("R2 line_start at 0", int'(line_start), 1);
    check("R11 hblank at 0", int'(hblank), 1);
    @(negedge clk);
    check("R2 line_start drops", int'(line_start), 0);
    wait_pos(6);   check("R3 de before", int'(disp_en), 0);
    wait_pos(7);   check("R3 de rise 50", int'(disp_en), 1);
    wait_pos(32);  check("R11 hblank 32", int'(hblank), 1);
    wait_pos(33);  check("R11 hblank 33", int'(hblank), 0);
    wait_pos(376); check("R5 de at 376", int'(disp_en), 1);
    wait_pos(377); check("R5 de cleared", int'(disp_en), 0);
    wait_pos(511); @(negedge clk);
    check("R2 50Hz length", int'(line_pos), 0);
  endtask

  task automatic t_line60;
    wait_pos(400); wr(1'b1, 2'b00);
    wait_pos(0);
    wait_pos(372); check("R4 de at 372", int'(disp_en), 1);
    wait_pos(373); check("R4 de cleared", int'(disp_en), 0);
    wait_pos(507); @(negedge clk);
    check("R2 60Hz length", int'(line_pos), 0);
  endtask

  task automatic t_open;
    wait_pos(100); wr(1'b1, 2'b10);
    wait_pos(0);
    wait_pos(374); wr(1'b1, 2'b00);
    wait_pos(377); check("R7 open after 376", int'(disp_en), 1);
    wait_pos(511); check("R7 open at line end", int'(disp_en), 1);
    @(negedge clk);
    check("R2 length kept 512 after mode change", int'(line_pos), 0);
    wait_pos(5);   check("R7 open into next line", int'(disp_en), 1);
    wait_pos(372); check("R4 de at 372 b", int'(disp_en), 1);
    wait_pos(373); check("R4 de cleared b", int'(disp_en), 0);
  endtask

  task automatic t_skew;
    wait_pos(400); wr(1'b1, 2'b10);
    wait_pos(0);
    wait_pos(375); wr(1'b1, 2'b00);
    check("R9 sync late de at 376", int'(disp_en), 1);
    wait_pos(377); check("R9 sync write at 375 too late", int'(disp_en), 0);
    wait_pos(400); wr(1'b1, 2'b10);
    wait_pos(0);
    wait_pos(375); wr(1'b0, 2'b10);
    wait_pos(377); check("R8 res write at 375 in time", int'(disp_en), 1);
    wait_pos(511); @(negedge clk);
    check("R2 length kept 512 after res change", int'(line_pos), 0);
  endtask

  task automatic t_hires;
    wait_pos(184); check("R6 de at 184", int'(disp_en), 1);
    wait_pos(185); check("R6 de cleared", int'(disp_en), 0);
    wait_pos(190); wr(1'b1, 2'b00);
    wait_pos(223); @(negedge clk);
    check("R2 hires length", int'(line_pos), 0);
    wait_pos(4);   check("R3 hires de before", int'(disp_en), 0);
    wait_pos(5);   check("R3 hires de rise", int'(disp_en), 1);
    wait_pos(33);  check("R11 hires hblank 33", int'(hblank), 0);
    wait_pos(223); @(negedge clk);
    check("R1 hires over sync 60", int'(line_pos), 0);
  endtask

  task automatic t_long;
    wait_pos(100); wr(1'b0, 2'b00);
    wait_pos(185); check("R6 no clear in 60 mode", int'(disp_en), 1);
    wait_pos(223); @(negedge clk);
    wait_pos(50);  wr(1'b1, 2'b10);
    wait_pos(0);
    wait_pos(372);
    wr_stb = 1'b1; wr_sel = 1'b1; wr_data = 2'b11;
    @(negedge clk); wr_data = 2'b11;
    @(negedge clk); wr_data = 2'b00;
    @(negedge clk); wr_stb = 1'b0;
    check("R9 no capture during strobe", int'(sync_drive), 1);
    wait_pos(377); check("R9 last strobe data opens border", int'(disp_en), 1);
  endtask

  task automatic t_ext;
    wait_pos(100); wr(1'b1, 2'b11);
    wait_pos(104);
    check("R10 de low", int'(disp_en), 0);
    check("R10 sync_drive low", int'(sync_drive), 0);
    wait_pos(7);   check("R10 no rise under ext", int'(disp_en), 0);
    wr(1'b1, 2'b10);
    wait_pos(200);
    check("R10 sync_drive back", int'(sync_drive), 1);
    check("R3 no rise after 6", int'(disp_en), 0);
    wait_pos(7);   check("R3 rise after ext off", int'(disp_en), 1);
  endtask

  initial begin
    t_reset;
    t_line50;
    t_line60;
    t_open;
    t_skew;
    t_hires;
    t_long;
    t_ext;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule